// File: doc/BRIEF.md
# RV32I Integer Execute Unit with Instruction Decode

This block is the combinational execute stage for the 32-bit base integer instruction set. It is given the raw opcode, funct3 and funct7 fields of one instruction, its 12-bit and 20-bit immediate fields, the two source register values and the program counter. From these it forms the value that the pipeline writes back to the destination register.

The block covers register-register arithmetic, logic, compare and shift operations. It also covers their register-immediate forms, the two upper-immediate instructions, and the link value of the two jump instructions. Any encoding outside that set raises an illegal flag, and the result is then forced to zero. The register file, loads and stores, the branch decision and all sequencing stay outside the block.

The decoder only classifies the instruction and picks the operands. The arithmetic unit is the same for every class. AUIPC and the link value therefore reuse the adder, with the PC as the first operand.

Top module: `rvx_exec`

## Requirements
- R1: With opcode 0x33 and funct3 0, the result is rs1+rs2 when funct7 is 0x00 and rs1-rs2 when funct7 is 0x20, both taken modulo 2^32.
- R2: With opcode 0x33 and funct7 0x00, funct3 values 1, 4, 6 and 7 give rs1 shifted left, XOR, OR and AND. A left shift fills zeros.
- R3: funct3 2 performs a signed less-than and funct3 3 an unsigned less-than, in both the register form and the immediate form. The result is 1 or 0 in bit 0, and bits 31..1 are zero.
- R4: funct3 5 shifts right. Zeros fill from the top when the seven upper bits (funct7 or imm12[11:5]) are 0x00. Copies of bit 31 fill from the top when those bits are 0x20. Register shifts use only rs2[4:0] as the amount.
- R5: With opcode 0x13, funct3 values 0, 2, 3, 4, 6 and 7 apply add, signed compare, unsigned compare, XOR, OR and AND. The second operand is imm12 sign-extended to 32 bits, and any imm12 value is legal.
- R6: With opcode 0x13, funct3 1 (left) and funct3 5 (right) shift by imm12[4:0]. funct3 1 requires imm12[11:5]=0x00. funct3 5 accepts only 0x00 or 0x20.
- R7: With opcode 0x37, the result is imm20 in bits 31..12, and bits 11..0 are zero.
- R8: With opcode 0x17, the result is pc + (imm20 << 12) modulo 2^32.
- R9: With opcode 0x6F, or with opcode 0x67 and funct3 0, the result is pc+4.
- R10: The illegal flag is 1 in each of these cases: any opcode outside {0x33, 0x13, 0x37, 0x17, 0x6F, 0x67}; opcode 0x33 with funct7 other than 0x00, except funct7 0x20 with funct3 0 or 5; an immediate shift whose upper bits are not allowed by R6, including a set imm12[5]; opcode 0x67 with funct3 other than 0. Whenever the flag is 1 the result is 0.
- R11: funct7 has no effect outside opcode 0x33. imm12 and imm20 have no effect on opcode 0x33.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 7 | Major opcode field |
| funct3 | input | 3 | Minor operation field |
| funct7 | input | 7 | Upper operation field of register-register instructions |
| imm12 | input | 12 | Raw 12-bit immediate field of the I-type forms |
| imm20 | input | 20 | Raw 20-bit upper immediate field |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| pc | input | 32 | Address of the instruction |
| wb_val | output | 32 | Value written to the destination register |
| illegal | output | 1 | The encoding is not a supported instruction |

## Verification
The legality check and the result computation are evaluated together for every encoding. Near a legal boundary, one of them must switch while the other gives way. The bench places encodings one field away from a legal instruction: a funct7 of 0x20 on an AND, an SLLI with imm12[5] set, an SRAI-like upper field of 0x21, and a JALR with non-zero funct3. Each of these must raise the flag and zero the result, while the legal neighbour in the next cycle still gives its computed value. A reference model in the bench judges both outputs on every item, including a long run of randomly filled fields over all opcodes.

// File: rtl/rvx_pkg.sv
package rvx_pkg;

  localparam logic [6:0] OPC_REG   = 7'h33;
  localparam logic [6:0] OPC_IMM   = 7'h13;
  localparam logic [6:0] OPC_LUI   = 7'h37;
  localparam logic [6:0] OPC_AUIPC = 7'h17;
  localparam logic [6:0] OPC_JAL   = 7'h6F;
  localparam logic [6:0] OPC_JALR  = 7'h67;

  localparam logic [6:0] UPPER_PLAIN = 7'h00;
  localparam logic [6:0] UPPER_ALT   = 7'h20;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_SLL, K_SLT, K_SLTU, K_XOR,
    K_SRL, K_SRA, K_OR, K_AND, K_PASSB
  } alu_kind_e;

  typedef enum logic [0:0] {A_RS1, A_PC} asel_e;

  typedef enum logic [1:0] {B_RS2, B_IMMI, B_IMMU, B_FOUR} bsel_e;

  // funct3 meaning shared by register and immediate forms
  function automatic alu_kind_e kind_of_f3(input logic [2:0] f3, input logic alt);
    case (f3)
      3'd0:    return alt ? K_SUB : K_ADD;
      3'd1:    return K_SLL;
      3'd2:    return K_SLT;
      3'd3:    return K_SLTU;
      3'd4:    return K_XOR;
      3'd5:    return alt ? K_SRA : K_SRL;
      3'd6:    return K_OR;
      default: return K_AND;
    endcase
  endfunction

endpackage

// File: rtl/rvx_decode.sv
module rvx_decode
  import rvx_pkg::*;
(
  input  logic [6:0]  opcode,
  input  logic [2:0]  funct3,
  input  logic [6:0]  funct7,
  input  logic [11:0] imm12,
  output alu_kind_e   kind,
  output asel_e       asel,
  output bsel_e       bsel,
  output logic        illegal
);

  logic is_reg, is_imm, is_lui, is_auipc, is_jal, is_jalr, is_none;
  logic [6:0] imm_upper;
  logic reg_f7_ok, imm_shift_ok;

  assign is_reg   = (opcode == OPC_REG);
  assign is_imm   = (opcode == OPC_IMM);
  assign is_lui   = (opcode == OPC_LUI);
  assign is_auipc = (opcode == OPC_AUIPC);
  assign is_jal   = (opcode == OPC_JAL);
  assign is_jalr  = (opcode == OPC_JALR);
  assign is_none  = !(is_reg || is_imm || is_lui || is_auipc || is_jal || is_jalr);

  assign imm_upper = imm12[11:5];

  // register form: plain upper field always, alternate only for sub / arithmetic shift
  assign reg_f7_ok = (funct7 == UPPER_PLAIN) ||
                     ((funct7 == UPPER_ALT) && (funct3 == 3'd0 || funct3 == 3'd5));

  // immediate shifts: left needs plain, right accepts plain or alternate
  assign imm_shift_ok = (funct3 == 3'd1) ? (imm_upper == UPPER_PLAIN) :
                        (funct3 == 3'd5) ? (imm_upper == UPPER_PLAIN || imm_upper == UPPER_ALT) :
                        1'b1;

  always_comb begin
    kind    = K_ADD;
    asel    = A_RS1;
    bsel    = B_RS2;
    illegal = 1'b0;
    if (is_reg) begin
      kind    = kind_of_f3(funct3, funct7 == UPPER_ALT);
      illegal = !reg_f7_ok;
    end else if (is_imm) begin
      bsel    = B_IMMI;
      kind    = kind_of_f3(funct3, (funct3 == 3'd5) && (imm_upper == UPPER_ALT));
      illegal = !imm_shift_ok;
    end else if (is_lui) begin
      kind = K_PASSB;
      bsel = B_IMMU;
    end else if (is_auipc) begin
      asel = A_PC;
      bsel = B_IMMU;
    end else if (is_jal || is_jalr) begin
      asel    = A_PC;
      bsel    = B_FOUR;
      illegal = is_jalr && (funct3 != 3'd0);
    end else begin
      illegal = 1'b1;
    end
  end

  always_comb begin
    p_class_onehot_r10: assert ($onehot({is_reg, is_imm, is_lui, is_auipc, is_jal, is_jalr, is_none}))
      else $error("decode classes not one-hot");
    p_imm_no_sub_r5: assert (!(is_imm && kind == K_SUB))
      else $error("immediate form decoded as subtract");
    p_slli_upper_r6: assert (!(is_imm && funct3 == 3'd1 && imm12[5] && !illegal))
      else $error("left immediate shift with bit 5 accepted");
  end

endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
  import rvx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_kind_e        kind,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y
);

  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] shamt;
  assign shamt = b[SHW-1:0];

  function automatic logic [XLEN-1:0] f_shift_right(input logic [XLEN-1:0] v,
                                                    input logic [SHW-1:0] s,
                                                    input logic arith);
    logic [XLEN-1:0] fill;
    fill = {XLEN{arith & v[XLEN-1]}};
    return (v >> s) | ~({XLEN{1'b1}} >> s) & fill;
  endfunction

  function automatic logic f_less(input logic [XLEN-1:0] x,
                                  input logic [XLEN-1:0] z,
                                  input logic signed_cmp);
    logic [XLEN-1:0] bias;
    bias = {signed_cmp, {(XLEN-1){1'b0}}};
    return (x ^ bias) < (z ^ bias);
  endfunction

  always_comb begin
    case (kind)
      K_ADD:   y = a + b;
      K_SUB:   y = a - b;
      K_SLL:   y = a << shamt;
      K_SLT:   y = {{(XLEN-1){1'b0}}, f_less(a, b, 1'b1)};
      K_SLTU:  y = {{(XLEN-1){1'b0}}, f_less(a, b, 1'b0)};
      K_XOR:   y = a ^ b;
      K_SRL:   y = f_shift_right(a, shamt, 1'b0);
      K_SRA:   y = f_shift_right(a, shamt, 1'b1);
      K_OR:    y = a | b;
      K_AND:   y = a & b;
      default: y = b;
    endcase
  end

  always_comb begin
    p_cmp_bit0_r3: assert (!((kind == K_SLT || kind == K_SLTU) && (y[XLEN-1:1] != '0)))
      else $error("compare result wider than one bit");
    p_sra_sign_r4: assert (!(kind == K_SRA && y[XLEN-1] != a[XLEN-1]))
      else $error("arithmetic shift lost sign");
    p_srl_zero_r4: assert (!(kind == K_SRL && shamt != '0 && y[XLEN-1]))
      else $error("logical shift filled with one");
  end

endmodule

// File: rtl/rvx_exec.sv
module rvx_exec
  import rvx_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 12,
  parameter int UIMM_W = 20
) (
  input  logic [6:0]        opcode,
  input  logic [2:0]        funct3,
  input  logic [6:0]        funct7,
  input  logic [IMM_W-1:0]  imm12,
  input  logic [UIMM_W-1:0] imm20,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [XLEN-1:0]   rs2_val,
  input  logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   wb_val,
  output logic              illegal
);

  localparam int ULOW = XLEN - UIMM_W;

  alu_kind_e       kind;
  asel_e           asel;
  bsel_e           bsel;
  logic            dec_illegal;
  logic [XLEN-1:0] op_a, op_b, alu_y;
  logic [XLEN-1:0] imm_i_ext, imm_u_ext;

  rvx_decode u_dec (
    .opcode  (opcode),
    .funct3  (funct3),
    .funct7  (funct7),
    .imm12   (imm12),
    .kind    (kind),
    .asel    (asel),
    .bsel    (bsel),
    .illegal (dec_illegal)
  );

  assign imm_i_ext = {{(XLEN-IMM_W){imm12[IMM_W-1]}}, imm12};
  assign imm_u_ext = {imm20, {ULOW{1'b0}}};

  assign op_a = (asel == A_PC) ? pc : rs1_val;

  always_comb begin
    case (bsel)
      B_RS2:   op_b = rs2_val;
      B_IMMI:  op_b = imm_i_ext;
      B_IMMU:  op_b = imm_u_ext;
      default: op_b = XLEN'(4);
    endcase
  end

  rvx_alu #(.XLEN(XLEN)) u_alu (
    .kind (kind),
    .a    (op_a),
    .b    (op_b),
    .y    (alu_y)
  );

  assign illegal = dec_illegal;
  assign wb_val  = dec_illegal ? '0 : alu_y;

  always_comb begin
    p_illegal_zero_r10: assert (!(illegal && wb_val != '0))
      else $error("illegal encoding left a non-zero result");
    p_lui_low_clear_r7: assert (!(opcode == OPC_LUI && wb_val[ULOW-1:0] != '0))
      else $error("upper immediate low bits not clear");
    p_jal_link_r9: assert (!(opcode == OPC_JAL && wb_val != pc + XLEN'(4)))
      else $error("jump link value wrong");
    p_lui_legal_r10: assert (!(opcode == OPC_LUI && illegal))
      else $error("upper immediate flagged illegal");
  end

endmodule

// File: tb/rvx_exec_test.sv
module rvx_exec_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  opcode = '0;
  logic [2:0]  funct3 = '0;
  logic [6:0]  funct7 = '0;
  logic [11:0] imm12 = '0;
  logic [19:0] imm20 = '0;
  logic [31:0] rs1_val = '0, rs2_val = '0, pc = '0;
  logic [31:0] wb_val;
  logic        illegal;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic [31:0] q_res[$];
  logic        q_ill[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rvx_exec uut (
    .opcode(opcode), .funct3(funct3), .funct7(funct7), .imm12(imm12), .imm20(imm20),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .pc(pc), .wb_val(wb_val), .illegal(illegal)
  );

  // reference model restating the requirements
  function automatic void model(input logic [6:0] op, input logic [2:0] f3, input logic [6:0] f7,
                                input logic [11:0] i12, input logic [19:0] u20,
                                input logic [31:0] x, input logic [31:0] y, input logic [31:0] p,
                                output logic [31:0] r, output logic bad);
    logic [31:0] src2;
    logic [6:0]  hi;
    logic        alt;
    r = 32'h0; bad = 1'b0; alt = 1'b0; src2 = y;
    case (op)
      7'h33: begin
        if (f7 == 7'h20) begin
          alt = 1'b1;
          bad = !(f3 == 3'd0 || f3 == 3'd5);
        end else bad = (f7 != 7'h00);
      end
      7'h13: begin
        src2 = 32'($signed(i12));
        hi = i12[11:5];
        if (f3 == 3'd1) bad = (hi != 7'h00);
        if (f3 == 3'd5) begin
          bad = !(hi == 7'h00 || hi == 7'h20);
          alt = (hi == 7'h20);
        end
      end
      7'h37: r = {u20, 12'h000};
      7'h17: r = p + {u20, 12'h000};
      7'h6F: r = p + 32'd4;
      7'h67: begin bad = (f3 != 3'd0); r = p + 32'd4; end
      default: bad = 1'b1;
    endcase
    if (op == 7'h33 || op == 7'h13) begin
      case (f3)
        3'd0: r = (alt && op == 7'h33) ? x - src2 : x + src2;
        3'd1: r = x << src2[4:0];
        3'd2: r = ($signed(x) < $signed(src2)) ? 32'd1 : 32'd0;
        3'd3: r = (x < src2) ? 32'd1 : 32'd0;
        3'd4: r = x ^ src2;
        3'd5: r = alt ? 32'($signed(x) >>> src2[4:0]) : x >> src2[4:0];
        3'd6: r = x | src2;
        3'd7: r = x & src2;
        default: r = 32'h0;
      endcase
    end
    if (bad) r = 32'h0;
  endfunction

  task automatic drive(input string tag, input logic [6:0] op, input logic [2:0] f3,
                       input logic [6:0] f7, input logic [11:0] i12, input logic [19:0] u20,
                       input logic [31:0] x, input logic [31:0] y, input logic [31:0] p);
    logic [31:0] er;
    logic        eb;
    model(op, f3, f7, i12, u20, x, y, p, er, eb);
    @(posedge clk);
    opcode = op; funct3 = f3; funct7 = f7; imm12 = i12; imm20 = u20;
    rs1_val = x; rs2_val = y; pc = p;
    q_res.push_back(er); q_ill.push_back(eb); q_tag.push_back(tag);
  endtask

  // monitor: compares away from the driving edge
  always @(negedge clk) begin
    if (q_res.size() > 0) begin
      logic [31:0] er;
      logic        eb;
      string       t;
      er = q_res.pop_front(); eb = q_ill.pop_front(); t = q_tag.pop_front();
      n_checks++;
      if (wb_val !== er || illegal !== eb) begin
        n_fails++;
        $display("FAIL %s: got wb=%h ill=%b expected wb=%h ill=%b (op=%h f3=%0d f7=%h imm12=%h)",
                 t, wb_val, illegal, er, eb, opcode, funct3, funct7, imm12);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got running expected finished");
      finish_run();
    end
  end

  initial begin
    // reset state: all-zero inputs form an unsupported opcode
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (wb_val !== 32'h0 || illegal !== 1'b1) begin
      n_fails++;
      $display("FAIL R10 reset: got wb=%h ill=%b expected wb=0 ill=1", wb_val, illegal);
    end

    drive("R1 add",   7'h33, 3'd0, 7'h00, 12'h0, 20'h0, 32'd5, 32'd7, 32'h0);
    drive("R1 sub",   7'h33, 3'd0, 7'h20, 12'h0, 20'h0, 32'd5, 32'd7, 32'h0);
    drive("R1 wrap",  7'h33, 3'd0, 7'h00, 12'h0, 20'h0, 32'hFFFFFFFF, 32'd2, 32'h0);
    drive("R2 sll",   7'h33, 3'd1, 7'h00, 12'h0, 20'h0, 32'h1, 32'd31, 32'h0);
    drive("R2 xor",   7'h33, 3'd4, 7'h00, 12'h0, 20'h0, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0);
    drive("R2 or",    7'h33, 3'd6, 7'h00, 12'h0, 20'h0, 32'hF0F0F0F0, 32'h0F000001, 32'h0);
    drive("R2 and",   7'h33, 3'd7, 7'h00, 12'h0, 20'h0, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0);
    drive("R3 slt",   7'h33, 3'd2, 7'h00, 12'h0, 20'h0, 32'hFFFFFFFF, 32'd1, 32'h0);
    drive("R3 sltu",  7'h33, 3'd3, 7'h00, 12'h0, 20'h0, 32'hFFFFFFFF, 32'd1, 32'h0);
    drive("R3 slti",  7'h13, 3'd2, 7'h00, 12'hFFF, 20'h0, 32'h80000000, 32'h0, 32'h0);
    drive("R3 sltiu", 7'h13, 3'd3, 7'h00, 12'hFFF, 20'h0, 32'h00000005, 32'h0, 32'h0);
    drive("R4 srl",   7'h33, 3'd5, 7'h00, 12'h0, 20'h0, 32'h80000000, 32'd4, 32'h0);
    drive("R4 sra",   7'h33, 3'd5, 7'h20, 12'h0, 20'h0, 32'h80000000, 32'd4, 32'h0);
    drive("R4 amt",   7'h33, 3'd1, 7'h00, 12'h0, 20'h0, 32'h3, 32'hFFFFFFE3, 32'h0);
    drive("R5 addi",  7'h13, 3'd0, 7'h00, 12'h800, 20'h0, 32'd100, 32'h0, 32'h0);
    drive("R5 xori",  7'h13, 3'd4, 7'h00, 12'hFFF, 20'h0, 32'h12345678, 32'h0, 32'h0);
    drive("R5 andi",  7'h13, 3'd7, 7'h00, 12'h7F0, 20'h0, 32'hFFFFFFFF, 32'h0, 32'h0);
    drive("R5 ori",   7'h13, 3'd6, 7'h00, 12'h801, 20'h0, 32'h0000000E, 32'h0, 32'h0);
    drive("R6 slli",  7'h13, 3'd1, 7'h00, 12'h01F, 20'h0, 32'h1, 32'h0, 32'h0);
    drive("R6 srai",  7'h13, 3'd5, 7'h00, 12'h408, 20'h0, 32'h80000000, 32'h0, 32'h0);
    drive("R6 srli",  7'h13, 3'd5, 7'h00, 12'h008, 20'h0, 32'h80000000, 32'h0, 32'h0);
    drive("R7 lui",   7'h37, 3'd5, 7'h7F, 12'hFFF, 20'hABCDE, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0);
    drive("R8 auipc", 7'h17, 3'd0, 7'h00, 12'h0, 20'hFFFFF, 32'h0, 32'h0, 32'h00002000);
    drive("R9 jal",   7'h6F, 3'd3, 7'h00, 12'h0, 20'h12345, 32'h0, 32'h0, 32'hFFFFFFFC);
    drive("R9 jalr",  7'h67, 3'd0, 7'h00, 12'h123, 20'h0, 32'h55, 32'h0, 32'h00001000);
    drive("R10 and-alt",  7'h33, 3'd7, 7'h20, 12'h0, 20'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0);
    drive("R10 add-f7",   7'h33, 3'd0, 7'h01, 12'h0, 20'h0, 32'd1, 32'd1, 32'h0);
    drive("R10 slli-b5",  7'h13, 3'd1, 7'h00, 12'h021, 20'h0, 32'h1, 32'h0, 32'h0);
    drive("R10 srai-21",  7'h13, 3'd5, 7'h00, 12'h421, 20'h0, 32'h80000000, 32'h0, 32'h0);
    drive("R10 jalr-f3",  7'h67, 3'd1, 7'h00, 12'h0, 20'h0, 32'h0, 32'h0, 32'h100);
    drive("R10 opcode",   7'h03, 3'd0, 7'h00, 12'h4, 20'h0, 32'h10, 32'h0, 32'h0);
    drive("R9 jalr-next", 7'h67, 3'd0, 7'h00, 12'h0, 20'h0, 32'h0, 32'h0, 32'h100);
    drive("R11 f7-imm",   7'h13, 3'd0, 7'h7F, 12'h001, 20'h0, 32'd9, 32'h0, 32'h0);
    drive("R11 imm-reg",  7'h33, 3'd0, 7'h00, 12'hFFF, 20'hFFFFF, 32'd9, 32'd1, 32'h0);

    for (int i = 0; i < 4000; i++) begin
      logic [6:0] op;
      logic [6:0] f7;
      logic [11:0] i12;
      case ($urandom_range(0, 7))
        0: op = 7'h33; 1: op = 7'h33; 2: op = 7'h13; 3: op = 7'h13;
        4: op = 7'h37; 5: op = 7'h17; 6: op = ($urandom_range(0, 1) != 0) ? 7'h6F : 7'h67;
        default: op = 7'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0: f7 = 7'h00; 1: f7 = 7'h20; 2: f7 = 7'h00; default: f7 = 7'($urandom);
      endcase
      i12 = 12'($urandom);
      if ($urandom_range(0, 2) == 0) i12[11:5] = ($urandom_range(0, 1) != 0) ? 7'h20 : 7'h00;
      drive("R10 random", op, 3'($urandom), f7, i12, 20'($urandom),
            $urandom, $urandom, $urandom);
    end

    @(posedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule